// File: doc/BRIEF.md
# Multiple-register transfer sequencer

This block turns a single "move many registers" request into a stream of single-word memory transfers. The request carries a base address, a 16-bit selection mask in which bit k stands for general register k, a two-bit ordering code, a load/store direction and a writeback request. After it is accepted, the block issues one transfer per selected register, one per clock cycle. Each transfer carries the register index, the word address and the load/store direction.

Registers always go out in ascending index order at ascending word addresses, stepping by four bytes. The ordering code decides only where that address run begins relative to the base, and whether the base moves up or down for writeback. When the run ends, the block pulses a done flag. If writeback was asked for, it also presents the updated base value so that the surrounding pipeline can write it back.

Top module: `mrt_seq`

## Requirements
- R1: After synchronous reset, `busy_o`, `xfer_valid_o`, `done_o` and `wb_valid_o` are all low.
- R2: An accepted request produces exactly one transfer per set mask bit. Transfers are issued on consecutive cycles, the first in the cycle after `start_i` is sampled, with `xfer_reg_o` strictly ascending.
- R3: Successive transfer addresses rise by 4, so the lowest selected register uses the lowest address.
- R4: With `order_i` = 2'b00 (up, step after) the first address is base. With `order_i` = 2'b01 (up, step before) it is base+4.
- R5: With `order_i` = 2'b10 (down, step after) the first address is base-4n+4. With `order_i` = 2'b11 (down, step before) it is base-4n. Here n is the number of set mask bits.
- R6: `xfer_load_o` on every transfer equals the `load_i` value sampled with the request (1 = load, 0 = store).
- R7: `done_o` is a single-cycle pulse in the cycle directly after the last transfer, and `busy_o` is low in the cycle after it.
- R8: An all-zero mask produces no transfer, and `done_o` rises in the cycle after the request is sampled.
- R9: When the request had `wb_req_i` = 1, `wb_valid_o` pulses together with `done_o` and `wb_base_o` equals base+4n for up orderings or base-4n for down orderings. Without the request, `wb_valid_o` stays low.
- R10: A `start_i` pulse while `busy_o` is high is ignored. The running sequence and its writeback value are unchanged.
- R11: Address and writeback arithmetic wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request strobe, taken when idle |
| base_i | input | 32 | Base address |
| reglist_i | input | 16 | Register selection mask, bit k = register k |
| order_i | input | 2 | Ordering: bit 1 = down, bit 0 = step before access |
| load_i | input | 1 | 1 = load, 0 = store |
| wb_req_i | input | 1 | Request updated base for writeback |
| busy_o | output | 1 | Sequence in progress |
| xfer_valid_o | output | 1 | A transfer is presented this cycle |
| xfer_reg_o | output | 4 | Register index of the transfer |
| xfer_addr_o | output | 32 | Word address of the transfer |
| xfer_load_o | output | 1 | Direction of the transfer |
| done_o | output | 1 | Sequence finished (one cycle) |
| wb_valid_o | output | 1 | Writeback value offered (one cycle) |
| wb_base_o | output | 32 | Updated base value |

## Verification
The hardest case to reach from the ports is a new request that arrives in the middle of a run. The block must ignore it, while the run's remaining transfers and its writeback value depend only on the request that was accepted. The stimulus creates this case by raising `start_i` in the cycle after a run begins, with a different base, mask and ordering. The scoreboard still expects only the original items. A second hard case is address wraparound. A down, step-before request on a base near zero drives both the first address and the writeback value across zero.

// File: rtl/mrt_pkg.sv
package mrt_pkg;

    typedef enum logic [1:0] {
        ORD_UP_AFTER  = 2'b00,
        ORD_UP_BEFORE = 2'b01,
        ORD_DN_AFTER  = 2'b10,
        ORD_DN_BEFORE = 2'b11
    } order_e;

    function automatic logic is_down(input order_e o);
        return o[1];
    endfunction

    function automatic logic is_before(input order_e o);
        return o[0];
    endfunction

endpackage

// File: rtl/mrt_popcnt.sv
module mrt_popcnt #(
    parameter int NREG = 16,
    localparam int CW = $clog2(NREG + 1)
) (
    input  logic [NREG-1:0] vec_i,
    output logic [CW-1:0]   cnt_o
);
    always_comb begin
        cnt_o = '0;
        for (int i = 0; i < NREG; i++) begin
            cnt_o = cnt_o + CW'(vec_i[i]);
        end
    end
endmodule

// File: rtl/mrt_lowpick.sv
module mrt_lowpick #(
    parameter int NREG = 16,
    localparam int IW = $clog2(NREG)
) (
    input  logic [NREG-1:0] vec_i,
    output logic [NREG-1:0] onehot_o,
    output logic [IW-1:0]   idx_o
);
    assign onehot_o = vec_i & (~vec_i + NREG'(1));

    for (genvar b = 0; b < IW; b++) begin : g_enc
        logic [NREG-1:0] sel;
        for (genvar k = 0; k < NREG; k++) begin : g_bit
            assign sel[k] = onehot_o[k] & ((k >> b) & 1) == 1;
        end
        assign idx_o[b] = |sel;
    end
endmodule

// File: rtl/mrt_addr_plan.sv
module mrt_addr_plan
    import mrt_pkg::*;
#(
    parameter int NREG = 16,
    parameter int AW   = 32,
    parameter int WB   = 4,
    localparam int CW  = $clog2(NREG + 1)
) (
    input  logic [AW-1:0] base_i,
    input  logic [CW-1:0] cnt_i,
    input  order_e        order_i,
    output logic [AW-1:0] first_o,
    output logic [AW-1:0] new_base_o
);
    logic [AW-1:0] span;
    logic [AW-1:0] low;

    assign span = AW'(cnt_i) * AW'(WB);
    assign low  = base_i - span;

    always_comb begin
        if (is_down(order_i)) begin
            first_o    = is_before(order_i) ? low : low + AW'(WB);
            new_base_o = low;
        end else begin
            first_o    = is_before(order_i) ? base_i + AW'(WB) : base_i;
            new_base_o = base_i + span;
        end
    end
endmodule

// File: rtl/mrt_seq.sv
module mrt_seq
    import mrt_pkg::*;
#(
    parameter int NREG = 16,
    parameter int AW   = 32,
    parameter int WB   = 4,
    localparam int IW  = $clog2(NREG),
    localparam int CW  = $clog2(NREG + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  logic [AW-1:0]   base_i,
    input  logic [NREG-1:0] reglist_i,
    input  logic [1:0]      order_i,
    input  logic            load_i,
    input  logic            wb_req_i,
    output logic            busy_o,
    output logic            xfer_valid_o,
    output logic [IW-1:0]   xfer_reg_o,
    output logic [AW-1:0]   xfer_addr_o,
    output logic            xfer_load_o,
    output logic            done_o,
    output logic            wb_valid_o,
    output logic [AW-1:0]   wb_base_o
);
    typedef struct packed {
        logic            busy;
        logic [NREG-1:0] mask;
        logic [AW-1:0]   addr;
        logic            load;
        logic            wb_req;
        logic [AW-1:0]   wb_base;
        logic [CW-1:0]   count;
    } run_t;

    run_t          st_q;
    logic [CW-1:0] req_cnt;
    logic [AW-1:0] first_addr;
    logic [AW-1:0] next_base;
    logic [NREG-1:0] pick_oh;
    logic [IW-1:0] pick_idx;
    logic          accept;
    logic          remaining;
    logic [CW-1:0] issued_q;

    mrt_popcnt #(.NREG(NREG)) u_cnt (
        .vec_i (reglist_i),
        .cnt_o (req_cnt)
    );

    mrt_addr_plan #(.NREG(NREG), .AW(AW), .WB(WB)) u_plan (
        .base_i     (base_i),
        .cnt_i      (req_cnt),
        .order_i    (order_e'(order_i)),
        .first_o    (first_addr),
        .new_base_o (next_base)
    );

    mrt_lowpick #(.NREG(NREG)) u_pick (
        .vec_i    (st_q.mask),
        .onehot_o (pick_oh),
        .idx_o    (pick_idx)
    );

    assign accept    = start_i && !st_q.busy;
    assign remaining = |st_q.mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else if (accept) begin
            st_q.busy    <= 1'b1;
            st_q.mask    <= reglist_i;
            st_q.addr    <= first_addr;
            st_q.load    <= load_i;
            st_q.wb_req  <= wb_req_i;
            st_q.wb_base <= next_base;
            st_q.count   <= req_cnt;
        end else if (st_q.busy) begin
            if (remaining) begin
                st_q.mask <= st_q.mask & ~pick_oh;
                st_q.addr <= st_q.addr + AW'(WB);
            end else begin
                st_q.busy <= 1'b0;
            end
        end
    end

    // transfer tally kept only for the checks below
    always_ff @(posedge clk) begin
        if (rst || accept) begin
            issued_q <= '0;
        end else if (xfer_valid_o) begin
            issued_q <= issued_q + CW'(1);
        end
    end

    assign busy_o       = st_q.busy;
    assign xfer_valid_o = st_q.busy && remaining;
    assign xfer_reg_o   = pick_idx;
    assign xfer_addr_o  = st_q.addr;
    assign xfer_load_o  = st_q.load;
    assign done_o       = st_q.busy && !remaining;
    assign wb_valid_o   = done_o && st_q.wb_req;
    assign wb_base_o    = st_q.wb_base;

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_valid_o && $past(xfer_valid_o) |-> xfer_addr_o == $past(xfer_addr_o) + AW'(WB));

    // R2
    reg_rise_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_valid_o && $past(xfer_valid_o) |-> xfer_reg_o > $past(xfer_reg_o));

    // R2
    xfer_total_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> issued_q == st_q.count);

    // R2
    pick_single_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pick_oh));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o && !busy_o);

    // R7
    done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(done_o && xfer_valid_o));

    // R9
    wb_gate_chk: assert property (@(posedge clk) disable iff (rst)
        wb_valid_o |-> done_o);

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o && start_i |=> $stable(wb_base_o) && $stable(xfer_load_o));

endmodule

// File: tb/mrt_seq_bench.sv
module mrt_seq_bench;

    typedef struct packed {
        logic [3:0]  r;
        logic [31:0] a;
        logic        l;
    } item_t;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic [31:0] base_i;
    logic [15:0] reglist_i;
    logic [1:0]  order_i;
    logic        load_i;
    logic        wb_req_i;
    logic        busy_o, xfer_valid_o, xfer_load_o, done_o, wb_valid_o;
    logic [3:0]  xfer_reg_o;
    logic [31:0] xfer_addr_o, wb_base_o;

    int    errors = 0;
    int    checks = 0;
    item_t q[$];
    string cur_tag = "R4";
    logic  exp_wbv;
    logic [31:0] exp_wbb;

    always #10 clk = ~clk;

    mrt_seq u_mrt_seq (
        .clk(clk), .rst(rst), .start_i(start_i), .base_i(base_i),
        .reglist_i(reglist_i), .order_i(order_i), .load_i(load_i),
        .wb_req_i(wb_req_i), .busy_o(busy_o), .xfer_valid_o(xfer_valid_o),
        .xfer_reg_o(xfer_reg_o), .xfer_addr_o(xfer_addr_o),
        .xfer_load_o(xfer_load_o), .done_o(done_o), .wb_valid_o(wb_valid_o),
        .wb_base_o(wb_base_o)
    );

    task automatic chk(input string req, input logic ok, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops expected transfers and compares them
    always @(negedge clk) begin
        if (!rst && xfer_valid_o) begin
            if (q.size() == 0) begin
                chk("R2 extra transfer", 1'b0, {28'd0, xfer_reg_o}, 32'hFFFF_FFFF);
            end else begin
                item_t e;
                e = q.pop_front();
                chk("R2 reg", xfer_reg_o == e.r, {28'd0, xfer_reg_o}, {28'd0, e.r});
                chk({cur_tag, " R3 addr"}, xfer_addr_o == e.a, xfer_addr_o, e.a);
                chk("R6 load", xfer_load_o == e.l, {31'd0, xfer_load_o}, {31'd0, e.l});
            end
        end
        if (!rst && done_o) begin
            chk("R2 missing transfers", q.size() == 0, q.size(), 0);
            chk("R9 wb valid", wb_valid_o == exp_wbv, {31'd0, wb_valid_o}, {31'd0, exp_wbv});
            if (exp_wbv) chk({cur_tag, " R9 wb base"}, wb_base_o == exp_wbb, wb_base_o, exp_wbb);
        end
    end

    task automatic run(input string tag, input logic [31:0] base, input logic [15:0] lst,
                       input logic [1:0] ord, input logic ld, input logic wb, input logic poke);
        int n = 0;
        int cycles;
        logic [31:0] a;
        for (int i = 0; i < 16; i++) if (lst[i]) n++;
        case (ord)
            2'b00:   a = base;
            2'b01:   a = base + 32'd4;
            2'b10:   a = base - 32'(4 * n) + 32'd4;
            default: a = base - 32'(4 * n);
        endcase
        cur_tag = tag;
        exp_wbv = wb;
        exp_wbb = ord[1] ? base - 32'(4 * n) : base + 32'(4 * n);
        for (int i = 0; i < 16; i++) begin
            if (lst[i]) begin
                q.push_back(item_t'{4'(i), a, ld});
                a = a + 32'd4;
            end
        end
        @(negedge clk);
        base_i = base; reglist_i = lst; order_i = ord; load_i = ld; wb_req_i = wb;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (n > 0) chk("R2 first transfer timing", xfer_valid_o, {31'd0, xfer_valid_o}, 1);
        else       chk("R8 empty list done", done_o && !xfer_valid_o, {31'd0, done_o}, 1);
        if (poke) begin
            base_i = 32'hDEAD_0000; reglist_i = 16'hFFFF; order_i = ~ord;
            load_i = ~ld; wb_req_i = ~wb; start_i = 1'b1;
        end
        cycles = 1;
        while (!done_o) begin
            @(negedge clk);
            start_i = 1'b0;
            cycles++;
        end
        chk("R7 done timing", cycles == n + 1, cycles, n + 1);
        @(negedge clk);
        chk("R7 idle after done", !busy_o && !done_o, {31'd0, busy_o}, 0);
        if (poke) chk("R10 late start ignored", !xfer_valid_o && q.size() == 0, {31'd0, xfer_valid_o}, 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; start_i = 1'b0; base_i = '0; reglist_i = '0;
        order_i = '0; load_i = 1'b0; wb_req_i = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset busy", !busy_o, {31'd0, busy_o}, 0);
        chk("R1 reset valid", !xfer_valid_o, {31'd0, xfer_valid_o}, 0);
        chk("R1 reset done", !done_o && !wb_valid_o, {31'd0, done_o}, 0);

        run("R4", 32'h0000_1000, 16'h8421, 2'b00, 1'b1, 1'b1, 1'b0);
        run("R4", 32'h0000_2000, 16'h00F0, 2'b01, 1'b0, 1'b0, 1'b0);
        run("R5", 32'h0000_3000, 16'hFFFF, 2'b10, 1'b1, 1'b1, 1'b0);
        run("R5", 32'h0000_4000, 16'h0001, 2'b11, 1'b0, 1'b1, 1'b0);
        run("R5", 32'h0000_5000, 16'h6006, 2'b11, 1'b1, 1'b1, 1'b0);
        run("R8", 32'h0000_6000, 16'h0000, 2'b11, 1'b0, 1'b1, 1'b0);
        run("R11", 32'h0000_0008, 16'h000F, 2'b11, 1'b1, 1'b1, 1'b0);
        run("R11", 32'hFFFF_FFF8, 16'h0007, 2'b01, 1'b0, 1'b1, 1'b0);
        run("R10", 32'h0000_7000, 16'h0303, 2'b00, 1'b1, 1'b1, 1'b1);
        run("R10", 32'h0000_8000, 16'h0003, 2'b10, 1'b0, 1'b0, 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule